// File: doc/BRIEF.md
# Address-Transition-Detect Read Sequencer

This block runs the read path of a NOR-style memory array without a read command. It keeps a registered copy of the address bus. Whenever the live address differs from that copy while the chip is selected, it opens a read cycle. During the cycle it drives the word line to the boosted level for a fixed decode/sense window. At the end of the window it pulses a latch strobe, captures the array data into the output latch, and lowers the word line to an intermediate hold level. The latched word stays on the data output until a later strobe replaces it.

A second timer measures how long the address has stayed unchanged. After the access window plus a safety margin, it raises the automatic-sleep flag and turns the word line off. The chip-enable, output-enable and write-enable pins play no part in this timing. Pulling chip-enable high selects a separate user standby state: the word line goes off and no read starts. If the address moved during standby, or a read was cut short by it, a read starts at once when chip-enable returns low. Every read, whether it starts after sleep or after standby, takes the same number of cycles. Analog pumps, the array and the sense amplifiers appear only as level codes, cycle counts and a data input.

Top module: `atd_read_seq`

## Requirements
- R1: While chip-enable is low, a cycle in which the address differs from the address seen in the previous cycle starts a read, and the word-line level reads 2'b10 (boost) from the next cycle on. No other control input is needed.
- R2: The word-line code uses 2'b00 = off, 2'b01 = hold and 2'b10 = boost; 2'b11 never appears. After an uninterrupted launch, boost lasts exactly SENSE_CYC cycles.
- R3: The latch strobe is high for exactly one cycle: the first cycle after boost ends. In that cycle the word-line level is hold.
- R4: From the strobe cycle on, the data output shows the array data that was present when boost ended, and it holds that value until the next strobe. When chip-enable or output-enable is high, the data output is 0 in the same cycle, with no clock delay.
- R5: If the address is unchanged for SENSE_CYC+MARGIN_CYC cycles after a launch, the sleep flag rises and the word-line level is off in cycle SENSE_CYC+MARGIN_CYC+1. The sleep flag clears on the next address change.
- R6: Sleep entry depends on the address alone. Toggling chip-enable or output-enable with the address held does not move the cycle in which sleep rises. An address change made during standby clears sleep and restarts the stability count.
- R7: Chip-enable high raises the standby flag and forces the word-line level to off from the next cycle. While it stays high, no strobe occurs and address changes start no read.
- R8: A read that starts from sleep, or from a chip-enable fall after the address moved during standby, shows the same SENSE_CYC boost cycles and the strobe in the same relative cycle as any other read.
- R9: An address change during boost, before the strobe, restarts the full SENSE_CYC boost window. The previously latched data stays on the output until the new strobe.
- R10: After reset the registered address is 0, the word-line level is off, and the strobe, sleep and standby flags are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | Address bus being watched for transitions |
| ce_n_i | input | 1 | Active-low chip enable; high selects standby |
| oe_n_i | input | 1 | Active-low output enable for the data output |
| arr_data_i | input | DATA_W | Sensed array word, captured at the strobe |
| wl_level_o | output | 2 | Word-line level code (00 off, 01 hold, 10 boost) |
| latch_stb_o | output | 1 | One-cycle data-latch strobe |
| data_o | output | DATA_W | Latched read word, gated by chip and output enable |
| sleep_o | output | 1 | Automatic-sleep flag |
| standby_o | output | 1 | User standby flag |

## Verification
The assertions assume that the address and enable inputs change only between clock edges and that the address is held at 0 during reset. Under those conditions, the address registered at the first edge after reset matches what the properties take as the previous address. The stability property also assumes that sleep cannot rise within two cycles of reset, which holds because SENSE_CYC and MARGIN_CYC are each at least 1. The bench drives every input at the falling clock edge and holds the address at 0 through reset. It keeps its enable pulses clear of the boost window, except where a boost interrupted by standby is the subject of the test.

// File: rtl/atd_pkg.sv
package atd_pkg;
   // Word-line level codes driven to the pump control.
   typedef enum logic [1:0] {
      WL_OFF   = 2'b00,
      WL_HOLD  = 2'b01,
      WL_BOOST = 2'b10
   } wl_lvl_e;
endpackage

// File: rtl/atd_change_det.sv
module atd_change_det #(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              ce_n_i,
   output logic              chg_o,
   output logic              ce_q_o
);
   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] diff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         ce_q_o <= 1'b0;
      end else begin
         addr_q <= addr_i;
         ce_q_o <= ce_n_i;
      end
   end

   // Per-bit transition detectors, merged into one change flag.
   for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
      assign diff[i] = addr_i[i] ^ addr_q[i];
   end

   assign chg_o = |diff;
endmodule

// File: rtl/atd_cycle_timer.sv
module atd_cycle_timer #(
   parameter int LIMIT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic en_i,
   output logic done_o
);
   localparam int CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   logic [CW-1:0] cnt_q;

   if (LIMIT < 1) begin : g_bad_limit
      $error("atd_cycle_timer: LIMIT must be at least 1");
   end

   // Saturating counter: holds at LAST until cleared.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr_i) begin
         cnt_q <= '0;
      end else if (en_i && (cnt_q != LAST)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign done_o = (cnt_q == LAST);
endmodule

// File: rtl/atd_read_seq.sv
module atd_read_seq
   import atd_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int DATA_W     = 8,
   parameter int SENSE_CYC  = 4,
   parameter int MARGIN_CYC = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              ce_n_i,
   input  logic              oe_n_i,
   input  logic [DATA_W-1:0] arr_data_i,
   output logic [1:0]        wl_level_o,
   output logic              latch_stb_o,
   output logic [DATA_W-1:0] data_o,
   output logic              sleep_o,
   output logic              standby_o
);
   localparam int SLEEP_CYC = SENSE_CYC + MARGIN_CYC;

   if (ADDR_W < 1) begin : g_bad_addr
      $error("atd_read_seq: ADDR_W must be at least 1");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("atd_read_seq: DATA_W must be at least 1");
   end
   if (SENSE_CYC < 1) begin : g_bad_sense
      $error("atd_read_seq: SENSE_CYC must be at least 1");
   end
   if (MARGIN_CYC < 1) begin : g_bad_margin
      $error("atd_read_seq: MARGIN_CYC must be at least 1");
   end

   wl_lvl_e           state_q, state_d;
   logic              chg, ce_q, ce_fall, pend_q;
   logic              launch, fire, stab_clr, stab_hit;
   logic              sense_done, stab_done;
   logic              stb_q, sleep_q;
   logic [DATA_W-1:0] data_q;

   atd_change_det #(.ADDR_W(ADDR_W)) u_det (
      .clk    (clk),
      .rst_n  (rst_n),
      .addr_i (addr_i),
      .ce_n_i (ce_n_i),
      .chg_o  (chg),
      .ce_q_o (ce_q)
   );

   assign ce_fall = ce_q & ~ce_n_i;
   // A read starts on an address change, or on leaving standby with a read owed.
   assign launch   = ~ce_n_i & (chg | (ce_fall & pend_q));
   assign stab_clr = chg | launch;

   atd_cycle_timer #(.LIMIT(SENSE_CYC)) u_sense (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (launch),
      .en_i   (state_q == WL_BOOST),
      .done_o (sense_done)
   );

   atd_cycle_timer #(.LIMIT(SLEEP_CYC)) u_stab (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (stab_clr),
      .en_i   (1'b1),
      .done_o (stab_done)
   );

   assign fire     = (state_q == WL_BOOST) & sense_done & ~launch & ~ce_n_i;
   assign stab_hit = stab_done & ~stab_clr;

   always_comb begin
      state_d = state_q;
      if (ce_n_i) begin
         state_d = WL_OFF;
      end else if (launch) begin
         state_d = WL_BOOST;
      end else begin
         case (state_q)
            WL_BOOST: if (sense_done) state_d = WL_HOLD;
            WL_HOLD:  if (stab_hit)   state_d = WL_OFF;
            default:  state_d = WL_OFF;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= WL_OFF;
         stb_q   <= 1'b0;
         data_q  <= '0;
         sleep_q <= 1'b0;
         pend_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         stb_q   <= fire;
         if (fire) begin
            data_q <= arr_data_i;
         end
         if (stab_clr) begin
            sleep_q <= 1'b0;
         end else if (stab_done) begin
            sleep_q <= 1'b1;
         end
         if (ce_n_i) begin
            pend_q <= pend_q | chg | (state_q == WL_BOOST);
         end else begin
            pend_q <= 1'b0;
         end
      end
   end

   assign wl_level_o  = state_q;
   assign latch_stb_o = stb_q;
   assign sleep_o     = sleep_q;
   assign standby_o   = ce_q;
   assign data_o      = (!ce_n_i && !oe_n_i) ? data_q : '0;
endmodule

// File: rtl/atd_read_seq_chk.sv
module atd_read_seq_chk #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr_i,
   input logic              ce_n_i,
   input logic              oe_n_i,
   input logic [1:0]        wl_level_o,
   input logic              latch_stb_o,
   input logic [DATA_W-1:0] data_o,
   input logic              sleep_o,
   input logic              standby_o
);
   p_boost_on_change_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n_i && (addr_i != $past(addr_i))) |=> (wl_level_o == 2'b10));

   p_wl_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wl_level_o != 2'b11);

   p_stb_after_boost_r3: assert property (@(posedge clk) disable iff (!rst_n)
      latch_stb_o |-> ((wl_level_o == 2'b01) && ($past(wl_level_o) == 2'b10)));

   p_stb_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      latch_stb_o |=> !latch_stb_o);

   p_data_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n_i && !oe_n_i && $past(!ce_n_i && !oe_n_i) && !latch_stb_o)
      |-> $stable(data_o));

   p_sleep_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_o |-> (wl_level_o == 2'b00));

   p_sleep_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sleep_o) |-> ($past(addr_i) == $past(addr_i, 2)));

   p_standby_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      standby_o |-> ((wl_level_o == 2'b00) && !latch_stb_o));
endmodule

bind atd_read_seq atd_read_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .addr_i      (addr_i),
   .ce_n_i      (ce_n_i),
   .oe_n_i      (oe_n_i),
   .wl_level_o  (wl_level_o),
   .latch_stb_o (latch_stb_o),
   .data_o      (data_o),
   .sleep_o     (sleep_o),
   .standby_o   (standby_o)
);

// File: tb/tb_atd_read_seq.sv
`timescale 1ns/100ps
module tb_atd_read_seq;
   localparam int AW = 4;
   localparam int DW = 8;
   localparam int S  = 3;
   localparam int M  = 4;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [AW-1:0] addr;
   logic          ce_n, oe_n;
   logic [DW-1:0] arr;
   logic [1:0]    wl;
   logic          stb, slp, stby;
   logic [DW-1:0] dout;

   int checks = 0;
   int errs   = 0;
   bit done   = 1'b0;
   logic [DW-1:0] cur;

   always #2.5 clk = ~clk;

   function automatic logic [DW-1:0] f(input logic [AW-1:0] a);
      return 8'h5A ^ {a, ~a};
   endfunction

   assign arr = f(addr);

   atd_read_seq #(.ADDR_W(AW), .DATA_W(DW), .SENSE_CYC(S), .MARGIN_CYC(M)) dut (
      .clk(clk), .rst_n(rst_n), .addr_i(addr), .ce_n_i(ce_n), .oe_n_i(oe_n),
      .arr_data_i(arr), .wl_level_o(wl), .latch_stb_o(stb), .data_o(dout),
      .sleep_o(slp), .standby_o(stby)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   // Starts a read (address change, or chip-enable fall when wake=1) and
   // follows it to sleep, checking every cycle against the timing model.
   task automatic do_read(input logic [AW-1:0] a, input bit wake);
      if (wake) ce_n = 1'b0;
      else addr = a;
      for (int k = 1; k <= S + M + 1; k++) begin
         @(negedge clk);
         chk(k == 1 ? "R1" : (wake ? "R8 wl" : "R2"), wl,
             k <= S ? 2'b10 : (k <= S + M ? 2'b01 : 2'b00));
         chk("R3 R8 strobe", stb, k == S + 1);
         chk("R4 data", dout, k <= S ? cur : f(a));
         chk("R5 sleep", slp, k == S + M + 1);
      end
      cur = f(a);
   endtask

   initial begin
      rst_n = 1'b0; addr = '0; ce_n = 1'b0; oe_n = 1'b0; cur = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 wl", wl, 2'b00);
      chk("R10 stb", stb, 1'b0);
      chk("R10 sleep", slp, 1'b0);
      chk("R10 standby", stby, 1'b0);
      chk("R10 data", dout, 8'h00);

      // Sweep every address; each read after the first starts from sleep (R8).
      for (int a = 1; a <= 16; a++) do_read(AW'(a), 1'b0);

      // Output-enable gating is combinational (R4).
      oe_n = 1'b1; #1;
      chk("R4 oe gate", dout, 8'h00);
      oe_n = 1'b0; #1;
      chk("R4 oe ungate", dout, cur);

      // Mid-cycle restart (R9).
      @(negedge clk);
      addr = 4'h9;
      @(negedge clk);
      chk("R9 boost a", wl, 2'b10);
      @(negedge clk);
      chk("R9 boost b", wl, 2'b10);
      addr = 4'h6;
      for (int k = 1; k <= S + 1; k++) begin
         @(negedge clk);
         chk("R9 wl", wl, k <= S ? 2'b10 : 2'b01);
         chk("R9 strobe", stb, k == S + 1);
         chk("R9 data", dout, k <= S ? cur : f(4'h6));
      end
      repeat (M) @(negedge clk);
      chk("R5 sleep after restart", slp, 1'b1);
      cur = f(4'h6);

      // Sleep timing unaffected by enable toggles (R6).
      addr = 4'hC;
      for (int k = 1; k <= S + M + 1; k++) begin
         @(negedge clk);
         if (k == S + M)     chk("R6 not yet", slp, 1'b0);
         if (k == S + M + 1) chk("R6 sleep", slp, 1'b1);
         if (k == S + 3)     chk("R7 standby", stby, 1'b1);
         if (k == S + 2) begin ce_n = 1'b1; oe_n = 1'b1; end
         if (k == S + 3) begin ce_n = 1'b0; oe_n = 1'b0; end
      end
      cur = f(4'hC);
      chk("R4 data after toggle", dout, cur);

      // Standby, address change during it, then wake (R7, R6, R8).
      ce_n = 1'b1;
      @(negedge clk);
      chk("R7 standby flag", stby, 1'b1);
      chk("R7 wl off", wl, 2'b00);
      chk("R4 ce gate", dout, 8'h00);
      addr = 4'h3;
      for (int k = 1; k <= S + M + 1; k++) begin
         @(negedge clk);
         chk("R7 wl", wl, 2'b00);
         chk("R7 no strobe", stb, 1'b0);
         chk("R6 standby sleep", slp, k == S + M + 1);
      end
      do_read(4'h3, 1'b1);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errs++;
         $display("FAIL watchdog: act=%0d exp=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end
endmodule